// File: doc/BRIEF.md
# Eight-Source Interrupt Status Controller

This block gathers eight single-cycle event pulses from the engines of a video accelerator into a latched status word. It raises one level-sensitive interrupt toward the host whenever a latched event is also unmasked. The sources are motion estimation, loop filtering, variable-length coding, host errors, DMA errors, sequencer mailbox traffic and two spares.

Software sees four registers on a 32-bit write/read port. The mask register and the status register read back what they hold. Two write-only strobe registers act on status. One drops bits by writing ones. The other raises bits by writing ones, which lets a test inject events without real hardware activity. Both strobe registers always read as zero.

Top module: `irq_status_ctrl`

## Requirements
- R1: Status bit assignment: bit 0 motion estimation, bit 1 loop filter, bit 2 variable-length coding, bit 3 spare, bit 4 host error, bit 5 DMA error, bit 6 sequencer mailbox, bit 7 spare. A high `evt_pulse[i]` at a rising clock edge makes status bit i read 1 right after that edge.
- R2: A write to byte offset 0x44 clears every status bit whose `wdata` bit is 1. Bits written 0 keep their value, and `wdata[31:8]` is ignored.
- R3: A write to byte offset 0x48 sets every status bit whose `wdata` bit is 1. Bits written 0 keep their value, and `wdata[31:8]` is ignored.
- R4: Reads at offsets 0x44 and 0x48 return 0 whatever status holds. Reads at any unmapped offset also return 0.
- R5: A write to offset 0x3C loads `wdata[7:0]` into the enable mask. Reads there return the mask in bits 7:0 and zero above. Writing the mask never alters status.
- R6: `irq` is a register that equals the OR of (status AND enable). It takes its new value at the same clock edge that updates status or enable.
- R7: When an event pulse and a clear write hit the same bit in the same cycle, the bit ends up set.
- R8: With `rst_n` low at a rising edge (synchronous, active low), status, enable and `irq` become 0.
- R9: `irq` stays high while any enabled status bit remains set. It falls only when the last such bit is cleared or masked.
- R10: Reads at offset 0x40 return status in bits 7:0 and zero above. Writes to offset 0x40 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 8 | Byte offset for both read and write |
| wdata | input | 32 | Write data |
| evt_pulse | input | 8 | Event pulses, one per status bit |
| rdata | output | 32 | Combinational read data for `addr` |
| irq | output | 1 | Level-sensitive interrupt to the host |

## Verification
Every piece of state in this block can be seen directly at the ports. A wrong status or mask bit therefore shows in `rdata` at 0x40 or 0x3C in the cycle right after the edge that stored it. It also shows as a wrong `irq` level at that same edge. The bench reads both registers and `irq` after every step. A misrouted strobe, a lost event or a mask write that touches status is caught one cycle after it happens.

// File: rtl/irq_status_ctrl.sv
module irq_status_ctrl #(
  parameter int NSRC = 8,
  parameter int AW   = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [NSRC-1:0] evt_pulse,
  output logic [DW-1:0] rdata,
  output logic          irq
);
  localparam logic [AW-1:0] OFS_EN  = AW'('h3C);
  localparam logic [AW-1:0] OFS_STS = AW'('h40);
  localparam logic [AW-1:0] OFS_CLR = AW'('h44);
  localparam logic [AW-1:0] OFS_SET = AW'('h48);
  localparam int PAD = DW - NSRC;

  logic [NSRC-1:0] sts, en, sts_d, en_d, clr_mask, set_mask;

  assign clr_mask = (wr_en && addr == OFS_CLR) ? wdata[NSRC-1:0] : '0;
  assign set_mask = (wr_en && addr == OFS_SET) ? wdata[NSRC-1:0] : '0;
  assign sts_d    = (sts & ~clr_mask) | set_mask | evt_pulse;
  assign en_d     = (wr_en && addr == OFS_EN) ? wdata[NSRC-1:0] : en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts <= '0;
      en  <= '0;
      irq <= 1'b0;
    end else begin
      sts <= sts_d;
      en  <= en_d;
      irq <= |(sts_d & en_d);
    end
  end

  always_comb begin
    case (addr)
      OFS_EN:  rdata = {{PAD{1'b0}}, en};
      OFS_STS: rdata = {{PAD{1'b0}}, sts};
      default: rdata = '0;
    endcase
  end

  AST_EVT_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_pulse) |=> ((sts & $past(evt_pulse)) == $past(evt_pulse))); // R1
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_CLR) |=> ((sts & $past(wdata[NSRC-1:0] & ~evt_pulse)) == '0)); // R2
  AST_SET_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_SET) |=> ((sts & $past(wdata[NSRC-1:0])) == $past(wdata[NSRC-1:0]))); // R3
  AST_STROBE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == OFS_CLR || addr == OFS_SET) |-> (rdata == '0)); // R4
  AST_MASK_KEEPS_STS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_EN && evt_pulse == '0) |=> $stable(sts)); // R5
  AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    irq == |(sts & en)); // R6
  AST_STS_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == OFS_STS && evt_pulse == '0) |=> $stable(sts)); // R10
endmodule

// File: tb/test_irq_status_ctrl.sv
module test_irq_status_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, irq;
  logic [7:0] addr = '0, evt_pulse = '0;
  logic [31:0] wdata = '0, rdata;
  int total = 0, bad = 0, cyc = 0;

  always #10 clk = ~clk;

  irq_status_ctrl i_irq_status_ctrl (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .evt_pulse(evt_pulse), .rdata(rdata), .irq(irq));

  // vector: req tag(8) wr(1) addr(8) wdata(32) evt(8) exp_sts(8) exp_en(8) exp_irq(1)
  localparam int NV = 14;
  localparam logic [73:0] VEC [NV] = '{
    {8'd5,  1'b1, 8'h3C, 32'h0000_0021, 8'h00, 8'h00, 8'h21, 1'b0}, // R5 mask load
    {8'd1,  1'b0, 8'h00, 32'h0,         8'h02, 8'h02, 8'h21, 1'b0}, // R1 loop-filter event, masked
    {8'd6,  1'b0, 8'h00, 32'h0,         8'h01, 8'h03, 8'h21, 1'b1}, // R6 motion event, enabled
    {8'd3,  1'b1, 8'h48, 32'hFFFF_FF80, 8'h00, 8'h83, 8'h21, 1'b1}, // R3 set bit 7, upper ignored
    {8'd2,  1'b1, 8'h44, 32'h0000_0002, 8'h00, 8'h81, 8'h21, 1'b1}, // R2 clear bit 1 only
    {8'd9,  1'b1, 8'h44, 32'h0000_0001, 8'h00, 8'h80, 8'h21, 1'b0}, // R9 last enabled bit cleared
    {8'd10, 1'b1, 8'h40, 32'h0000_00FF, 8'h00, 8'h80, 8'h21, 1'b0}, // R10 status write ignored
    {8'd5,  1'b1, 8'h3C, 32'hFFFF_FF80, 8'h00, 8'h80, 8'h80, 1'b1}, // R5 mask change, status kept
    {8'd7,  1'b1, 8'h44, 32'h0000_0080, 8'h80, 8'h80, 8'h80, 1'b1}, // R7 event beats clear
    {8'd2,  1'b1, 8'h44, 32'h0000_00FF, 8'h00, 8'h00, 8'h80, 1'b0}, // R2 clear all
    {8'd3,  1'b1, 8'h48, 32'h0000_0030, 8'h00, 8'h30, 8'h80, 1'b0}, // R3 set, masked no irq
    {8'd6,  1'b1, 8'h3C, 32'h0000_0010, 8'h00, 8'h30, 8'h10, 1'b1}, // R6 unmask raises irq
    {8'd1,  1'b0, 8'h00, 32'h0,         8'h44, 8'h74, 8'h10, 1'b1}, // R1 VLC and mailbox events
    {8'd9,  1'b1, 8'h3C, 32'h0000_0000, 8'h00, 8'h74, 8'h00, 1'b0}  // R9 masking drops irq
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a;
    #1 v = rdata;
  endtask

  task automatic step(input logic w, input logic [7:0] a, input logic [31:0] d, input logic [7:0] e);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; evt_pulse = e;
    @(posedge clk);
    #2 wr_en = 1'b0; evt_pulse = '0; wdata = '0;
  endtask

  task automatic check_state(input string req, input logic [7:0] s, input logic [7:0] m, input logic q);
    logic [31:0] v;
    rd(8'h40, v); chk(req, v, {24'h0, s});
    rd(8'h3C, v); chk(req, v, {24'h0, m});
    chk(req, {31'h0, irq}, {31'h0, q});
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected<=20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(posedge clk);
    #2 check_state("R8", 8'h00, 8'h00, 1'b0);
    rst_n = 1'b1;
    for (int k = 0; k < NV; k++) begin
      step(VEC[k][65], VEC[k][64:57], VEC[k][56:25], VEC[k][24:17]);
      check_state($sformatf("R%0d vec%0d", VEC[k][73:66], k), VEC[k][16:9], VEC[k][8:1], VEC[k][0]);
    end
    // R4: strobe and unmapped offsets read zero while status is nonzero
    rd(8'h44, v); chk("R4", v, 32'h0);
    rd(8'h48, v); chk("R4", v, 32'h0);
    rd(8'h50, v); chk("R4", v, 32'h0);
    // R9: two enabled bits, clearing one keeps irq
    step(1'b1, 8'h3C, 32'h03, 8'h00);
    step(1'b1, 8'h48, 32'h03, 8'h00);
    check_state("R9", 8'h77, 8'h03, 1'b1);
    step(1'b1, 8'h44, 32'h01, 8'h00);
    check_state("R9", 8'h76, 8'h03, 1'b1);
    step(1'b1, 8'h44, 32'h02, 8'h00);
    check_state("R9", 8'h74, 8'h03, 1'b0);
    // R8: synchronous reset in mid-run
    step(1'b1, 8'h48, 32'h03, 8'h00);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #2 check_state("R8", 8'h00, 8'h00, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule